// File: doc/BRIEF.md
# Configurable Trigger Line Controller

This block owns one bidirectional external trigger pin. While the pin faces inward, the block samples it through a two-flop synchronizer and applies a programmable polarity. It then emits a single-cycle acquisition-start pulse on the selected edge. The pulse fires only while the block is armed, and each pulse disarms the block until software arms it again.

While the pin faces outward, the block drives it from one of two kinds of source. One is a static level written by software. The other is one of several internal status signals, chosen by a source-select field. The chosen value passes through the same polarity control before it reaches the pad. Address decoding is left to the surrounding bus logic. The block therefore takes separate write strobes for its control field, its source field and its arm request.

Top module: `trig_line_ctrl`

## Requirements
- R1: After reset, `pin_oe` is 0, `pin_out` is 0 and `acq_start` is 0. The block starts disarmed, so a pin edge produces no pulse until `arm_we` is strobed.
- R2: `ctrl_wdata` has this layout: bit 0 is the direction (1 = output), bit 1 is invert, bit 2 is the edge select (1 = falling), bit 3 is the software level. With input direction, edge select 0, invert 0 and the block armed, a low-to-high change on `pin_in` gives exactly one `acq_start` cycle. That cycle is the third rising clock edge after the change.
- R3: With edge select 1 and invert 0, a high-to-low change on `pin_in` gives one pulse. A low-to-high change gives none.
- R4: Invert (ctrl bit 1) is applied to the sampled pin before edge detection. With invert set and rising edge selected, a high-to-low pin change gives a pulse and a low-to-high change gives none.
- R5: A pulse is produced only while armed. A pulse clears the armed state, so a second qualifying edge gives no pulse until `arm_we` is strobed again.
- R6: `pin_oe` equals the direction bit, one clock after the control write takes effect. While the direction is output, pin activity never produces `acq_start`.
- R7: With source select 0, `pin_out` equals the software level (ctrl bit 3) XOR invert.
- R8: With source select k, where 1 ≤ k ≤ N_STAT, `pin_out` equals `status_in[k-1]` XOR invert and follows that input with one cycle of latency.
- R9: With source select above N_STAT, `pin_out` holds the unasserted level, which is 0 XOR invert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Write strobe for the control field |
| ctrl_wdata | input | 4 | {sw_level, falling, invert, dir_out} |
| sel_we | input | 1 | Write strobe for the source select field |
| sel_wdata | input | SEL_W | Output source select value |
| arm_we | input | 1 | Arm request strobe |
| status_in | input | N_STAT | Internal status signals that can be mapped to the pin |
| pin_in | input | 1 | Pad input value |
| pin_out | output | 1 | Pad output value |
| pin_oe | output | 1 | Pad output enable |
| acq_start | output | 1 | One-cycle acquisition-start pulse |

## Verification
The bench builds the block with its defaults: six status inputs and a three-bit source field. With these values every legal mapping from 1 to 6 can be reached. Source value 7 remains a real out-of-range code, so the unasserted fallback gets exercised. Each status input in turn is driven to a walking one, which exposes an off-by-one in the source decode.

// File: rtl/trig_pkg.sv
// Package: shared encoding of the trigger control field.
// Assumes the control field is always four bits wide.
package trig_pkg;
    typedef struct packed {
        logic sw_level;  // static output level (asserted = 1)
        logic falling;   // edge select: 1 = falling
        logic invert;    // polarity invert
        logic dir_out;   // 1 = pin driven by block
    } trig_ctrl_t;

    localparam int CTRL_W = $bits(trig_ctrl_t);
endpackage

// File: rtl/trig_cfg_regs.sv
// Holds the control and source-select registers.
// Assumes the strobes are already decoded by the bus logic.
module trig_cfg_regs
    import trig_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_we,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic                sel_we,
    input  logic [SEL_W-1:0]    sel_wdata,
    output trig_ctrl_t          ctrl_q,
    output logic [SEL_W-1:0]    sel_q
);
    // Capture register writes; reset to input, no inversion, source 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            sel_q  <= '0;
        end else begin
            if (ctrl_we) ctrl_q <= trig_ctrl_t'(ctrl_wdata);
            if (sel_we)  sel_q  <= sel_wdata;
        end
    end
endmodule

// File: rtl/trig_in_detect.sv
// Input path: synchronizer, polarity, edge detect, arm gating.
// Assumes pin_in is asynchronous; the pulse is registered.
module trig_in_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic invert,
    input  logic falling,
    input  logic dir_out,
    input  logic arm_we,
    output logic acq_start,
    output logic armed
);
    logic sync1_q, sync2_q, lvl_q;
    logic lvl, edge_hit, fire;

    // Two-flop synchronizer plus previous polarity-corrected level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            lvl_q   <= 1'b0;
        end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
            lvl_q   <= lvl;
        end
    end

    // Select the qualifying edge and gate it with arm and direction.
    always_comb begin
        lvl      = sync2_q ^ invert;
        edge_hit = falling ? (lvl_q & ~lvl) : (lvl & ~lvl_q);
        fire     = edge_hit & armed & ~dir_out;
    end

    // Emit the pulse and self-disarm; an arm request takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acq_start <= 1'b0;
            armed     <= 1'b0;
        end else begin
            acq_start <= fire;
            if (arm_we)    armed <= 1'b1;
            else if (fire) armed <= 1'b0;
        end
    end
endmodule

// File: rtl/trig_out_mux.sv
// Output path: source mapping, polarity, registered pad drive.
// Assumes status_in is synchronous to clk.
module trig_out_mux #(
    parameter int N_STAT = 6,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_STAT-1:0] status_in,
    input  logic [SEL_W-1:0]  sel,
    input  logic              sw_level,
    input  logic              invert,
    input  logic              dir_out,
    output logic              pin_out,
    output logic              pin_oe
);
    logic raw;

    // Pick the asserted-sense source; out-of-range codes give unasserted.
    always_comb begin
        raw = 1'b0;
        if (sel == '0) raw = sw_level;
        for (int k = 0; k < N_STAT; k++) begin
            if (int'(sel) == k + 1) raw = status_in[k];
        end
    end

    // Register the pad value and its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_out <= 1'b0;
            pin_oe  <= 1'b0;
        end else begin
            pin_out <= raw ^ invert;
            pin_oe  <= dir_out;
        end
    end
endmodule

// File: rtl/trig_line_ctrl.sv
// Top: one trigger pin used as edge start input or mapped output.
// Assumes bus decoding yields separate strobes for each field.
module trig_line_ctrl
    import trig_pkg::*;
#(
    parameter int N_STAT = 6,
    parameter int SEL_W  = $clog2(N_STAT + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_we,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic                sel_we,
    input  logic [SEL_W-1:0]    sel_wdata,
    input  logic                arm_we,
    input  logic [N_STAT-1:0]   status_in,
    input  logic                pin_in,
    output logic                pin_out,
    output logic                pin_oe,
    output logic                acq_start
);
    trig_ctrl_t       ctrl_q;
    logic [SEL_W-1:0] sel_q;
    logic             armed;

    trig_cfg_regs #(.SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .sel_we(sel_we), .sel_wdata(sel_wdata),
        .ctrl_q(ctrl_q), .sel_q(sel_q)
    );

    trig_in_detect u_in (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .invert(ctrl_q.invert), .falling(ctrl_q.falling),
        .dir_out(ctrl_q.dir_out), .arm_we(arm_we),
        .acq_start(acq_start), .armed(armed)
    );

    trig_out_mux #(.N_STAT(N_STAT), .SEL_W(SEL_W)) u_out (
        .clk(clk), .rst_n(rst_n), .status_in(status_in), .sel(sel_q),
        .sw_level(ctrl_q.sw_level), .invert(ctrl_q.invert),
        .dir_out(ctrl_q.dir_out), .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/trig_line_ctrl_chk.sv
// Checker bound to the top; relates state and ports over time.
module trig_line_ctrl_chk #(
    parameter int N_STAT = 6,
    parameter int SEL_W  = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm_we,
    input logic             armed,
    input logic             invert,
    input logic             sw_level,
    input logic [SEL_W-1:0] sel_q,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             acq_start
);
    // R5: a pulse needs the armed state in the cycle before
    a_r5_pulse_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        acq_start |-> $past(armed));

    // R2: a pulse lasts one cycle unless re-armed at once
    a_r2_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_start && !$past(arm_we)) |=> !acq_start);

    // R6: no start pulse while the pad is driven
    a_r6_no_start_when_out: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> !acq_start);

    // R7: software level source
    a_r7_sw_level: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == '0) |=> (pin_out == $past(sw_level ^ invert)));

    // R9: out-of-range source gives unasserted level
    a_r9_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(sel_q) > N_STAT) |=> (pin_out == $past(invert)));
endmodule

bind trig_line_ctrl trig_line_ctrl_chk #(.N_STAT(N_STAT), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm_we(arm_we), .armed(armed),
    .invert(ctrl_q.invert), .sw_level(ctrl_q.sw_level), .sel_q(sel_q),
    .pin_out(pin_out), .pin_oe(pin_oe), .acq_start(acq_start)
);

// File: tb/trig_line_ctrl_bench.sv
module trig_line_ctrl_bench;
    localparam int N_STAT = 6;
    localparam int SEL_W  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctrl_we = 1'b0;
    logic [3:0]       ctrl_wdata = '0;
    logic             sel_we = 1'b0;
    logic [SEL_W-1:0] sel_wdata = '0;
    logic             arm_we = 1'b0;
    logic [N_STAT-1:0] status_in = '0;
    logic             pin_in = 1'b0;
    logic             pin_out, pin_oe, acq_start;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    trig_line_ctrl u_trig_line_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .sel_we(sel_we), .sel_wdata(sel_wdata), .arm_we(arm_we),
        .status_in(status_in), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .acq_start(acq_start)
    );

    task automatic check(input int act, input int exp, input string tag);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // ctrl bits: {sw_level, falling, invert, dir_out}
    task automatic write_ctrl(input logic [3:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
        wait_n(3);
    endtask

    task automatic write_sel(input int v);
        @(negedge clk); sel_we = 1'b1; sel_wdata = SEL_W'(v);
        @(negedge clk); sel_we = 1'b0;
        wait_n(2);
    endtask

    task automatic arm();
        @(negedge clk); arm_we = 1'b1;
        @(negedge clk); arm_we = 1'b0;
    endtask

    // Drive pin at a negedge; return pulse count and index of first pulse.
    task automatic drive_pin(input logic v, output int cnt, output int first);
        @(negedge clk); pin_in = v;
        cnt = 0; first = -1;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (acq_start) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
    endtask

    task automatic t_reset();
        int c, f;
        check(pin_oe, 0, "R1 oe");
        check(pin_out, 0, "R1 out");
        check(acq_start, 0, "R1 start");
        drive_pin(1'b1, c, f);
        check(c, 0, "R1 disarmed no pulse");
        drive_pin(1'b0, c, f);
    endtask

    task automatic t_rising();
        int c, f;
        write_ctrl(4'b0000);
        arm();
        drive_pin(1'b1, c, f);
        check(c, 1, "R2 rising pulse count");
        check(f, 3, "R2 rising latency");
        drive_pin(1'b0, c, f);
    endtask

    task automatic t_falling();
        int c, f;
        write_ctrl(4'b0100);
        arm();
        drive_pin(1'b1, c, f);
        check(c, 0, "R3 rising ignored");
        drive_pin(1'b0, c, f);
        check(c, 1, "R3 falling pulse");
    endtask

    task automatic t_invert();
        int c, f;
        write_ctrl(4'b0010);
        wait_n(4);
        arm();
        drive_pin(1'b1, c, f);
        check(c, 0, "R4 inverted rise ignored");
        drive_pin(1'b0, c, f);
        check(c, 1, "R4 inverted fall pulses");
    endtask

    task automatic t_disarm();
        int c, f;
        write_ctrl(4'b0000);
        arm();
        drive_pin(1'b1, c, f);
        check(c, 1, "R5 first pulse");
        drive_pin(1'b0, c, f);
        drive_pin(1'b1, c, f);
        check(c, 0, "R5 disarmed after pulse");
        drive_pin(1'b0, c, f);
        arm();
        drive_pin(1'b1, c, f);
        check(c, 1, "R5 rearmed pulse");
        drive_pin(1'b0, c, f);
    endtask

    task automatic t_direction();
        int c, f;
        write_ctrl(4'b0001);
        check(pin_oe, 1, "R6 oe high in output");
        arm();
        drive_pin(1'b1, c, f);
        check(c, 0, "R6 no pulse in output");
        drive_pin(1'b0, c, f);
        write_ctrl(4'b0000);
        check(pin_oe, 0, "R6 oe low in input");
    endtask

    task automatic t_sw_level();
        write_sel(0);
        write_ctrl(4'b1001);
        check(pin_out, 1, "R7 sw level high");
        write_ctrl(4'b0001);
        check(pin_out, 0, "R7 sw level low");
        write_ctrl(4'b1011);
        check(pin_out, 0, "R7 sw level inverted");
    endtask

    task automatic t_mapping();
        write_ctrl(4'b0001);
        for (int k = 1; k <= N_STAT; k++) begin
            write_sel(k);
            status_in = N_STAT'(1) << (k - 1);
            wait_n(2);
            check(pin_out, 1, $sformatf("R8 map %0d high", k));
            status_in = ~(N_STAT'(1) << (k - 1));
            wait_n(2);
            check(pin_out, 0, $sformatf("R8 map %0d low", k));
        end
        write_ctrl(4'b0011);
        status_in = '0;
        wait_n(2);
        check(pin_out, 1, "R8 map inverted");
    endtask

    task automatic t_out_of_range();
        status_in = '1;
        write_ctrl(4'b1001);
        write_sel(7);
        check(pin_out, 0, "R9 unasserted");
        write_ctrl(4'b1011);
        check(pin_out, 1, "R9 unasserted inverted");
        status_in = '0;
    endtask

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_rising();
        t_falling();
        t_invert();
        t_disarm();
        t_direction();
        t_sw_level();
        t_mapping();
        t_out_of_range();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        wait_n(20000);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule